// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block runs a four-wire resistive touch panel through one complete measurement pass and then decides whether a pen is on the panel. It drives a 16-bit panel control word that opens and closes the plate power and ground switches, selects the panel mode and turns on the bias. It obtains conversions from a separate ADC controller through a request, channel, done and data handshake. Each pass measures X, then Y, then pressure. Before each axis conversion the plates are configured in pressure mode and then switched to position mode, because this shortens the settling time.

Between passes the panel is held in pen-detect (interrupt) mode. After a pass, the block waits for the panel to settle and then reads the two low-sense lines. If neither line is set, the block emits a one-cycle sample strobe carrying X, Y and pressure, and schedules the next pass. If either line is set, it pulses a pen re-arm output, emits a release strobe if the previous decision produced a sample, and waits for a pen interrupt or a restart. Every delay is a microsecond parameter that is turned into clock cycles using a clock-frequency parameter.

Top module: `touch_scan_seq`

## Requirements
- R1: Reset state.
  - `ctrl_word_o` is 0x00C3.
  - `adc_en_o`, `adc_req_o`, `adc_chan_o`, all strobes, `x_o`, `y_o` and `p_o` are zero.
- R2: Idle behaviour.
  - While idle, the block holds the interrupt-mode word 0x00C3 with the ADC disabled.
  - A pass starts only when `pen_irq_i` or `restart_i` is high at a clock edge.
  - The first cycle of a pass keeps 0x00C3 with `adc_en_o` high.
- R3: Control word layout. Bits 3..0 power minus-X, plus-X, minus-Y and plus-Y. Bits 7..4 ground the same four plates in that order. Bits 9:8 are the mode (0 interrupt, 1 pressure, 2 position). Bit 11 is bias enable. All other bits are zero.
- R4: X read sequence.
  - The X plate word (0x0912) is driven for two cycles, then the position-mode word 0x0A12.
  - The block then holds 0x0A12 for the position settle time.
  - It then raises `adc_req_o` on channel 2 (plus-Y) and keeps the request and the channel steady until `adc_done_i` is seen at a clock edge. The data on that edge is the X result.
- R5: Y read sequence. It has the same shape as R4, using 0x0948 for two cycles, then 0x0A48, then the settle time, then a conversion on channel 0 (plus-X).
- R6: Pressure read.
  - 0x09C3 is driven for one cycle, then held for the pressure settle time, then a conversion is requested on channel 2.
  - A pressure settle time of zero means the conversion request follows the single write directly.
- R7: `adc_en_o` is high from the first cycle of a pass through the pressure conversion, and low at all other times. A request is never raised while the ADC is disabled.
- R8: After the pressure conversion, the block drives 0x00C3 with the ADC off for the pen-settle time, plus one decision cycle. `sense_i` is sampled at the end of the decision cycle.
- R9: Touched case (`sense_i` == 0).
  - In the next cycle `sample_vld_o` pulses for one cycle, and `x_o`, `y_o` and `p_o` take the three results of the pass. These outputs hold their values until the next sample.
  - The next pass starts after the rescan time.
- R10: Untouched case (any `sense_i` bit set).
  - In the next cycle `pen_arm_o` pulses for one cycle.
  - `release_o` pulses with it only if the previous decision was a touch.
  - The block then returns to idle.
- R11: During the rescan wait, `pen_irq_i` or `restart_i` starts a new pass at the next cycle, without waiting for the timer.
- R12: Each delay in cycles equals `CLK_MHZ` times its microsecond parameter. The defaults are 55 us for position settle, 0 us for pressure settle, and 10000 us each for pen settle and rescan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pen_irq_i | input | 1 | Pen-down interrupt; starts a pass when idle or during the rescan wait |
| restart_i | input | 1 | Restart request; same effect as a pen interrupt |
| sense_i | input | 2 | Plate low-sense readback {minus-X low, plus-X low} |
| adc_done_i | input | 1 | Conversion complete; accompanies valid data |
| adc_data_i | input | ADC_W | Conversion result |
| ctrl_word_o | output | 16 | Panel control word |
| adc_en_o | output | 1 | ADC enable |
| adc_req_o | output | 1 | Conversion request, held until done |
| adc_chan_o | output | CHAN_W | Channel to convert: 0 plus-X, 2 plus-Y, 0 when not requesting |
| pen_arm_o | output | 1 | One-cycle pulse to re-arm the pen interrupt |
| sample_vld_o | output | 1 | One-cycle sample strobe |
| release_o | output | 1 | One-cycle pen-release strobe |
| x_o | output | ADC_W | Last sampled X |
| y_o | output | ADC_W | Last sampled Y |
| p_o | output | ADC_W | Last sampled pressure |

## Verification
The bench drives ADC latencies of zero to three cycles. A design that assumed a fixed latency would capture stale data or drop its request before done arrives.

The bench runs an untouched pass both after a sample and after a previous untouched pass. A design that kept no memory of the last decision would emit a spurious release or miss the real one.

The bench raises a pen interrupt part-way through the rescan wait. A block that ignored it there would stay in interrupt mode until the timer expired.

With the pressure settle time set to zero, the bench checks that the single pressure write is followed directly by the request. It also counts the position-mode cycles of every pass to catch any off-by-one error in the settle timer.

// File: rtl/tss_pkg.sv
package tss_pkg;

   localparam int CW_W      = 16;
   localparam int B_PWR_LO  = 0;   // four power switches: mX, pX, mY, pY
   localparam int B_GND_LO  = 4;   // four ground switches, same plate order
   localparam int B_MODE_LO = 8;
   localparam int B_BIAS    = 11;

   typedef enum logic [1:0] {
      PM_INTR = 2'd0,
      PM_PRES = 2'd1,
      PM_POS  = 2'd2
   } panel_mode_e;

   typedef enum logic [4:0] {
      ST_IDLE, ST_ADC_ON,
      ST_XW1, ST_XW2, ST_XW3, ST_XSET, ST_XCONV,
      ST_YW1, ST_YW2, ST_YW3, ST_YSET, ST_YCONV,
      ST_PW, ST_PSET, ST_PCONV,
      ST_PENWAIT, ST_DECIDE, ST_RESCAN
   } scan_st_e;

   // ADC channel codes decoded by the converter
   localparam int CH_PLUS_X = 0;
   localparam int CH_PLUS_Y = 2;

   function automatic logic [CW_W-1:0] cw_make(input logic [3:0] pwr,
                                               input logic [3:0] gnd,
                                               input panel_mode_e mode,
                                               input logic bias);
      logic [CW_W-1:0] w;
      w = '0;
      w[B_PWR_LO +: 4]  = pwr;
      w[B_GND_LO +: 4]  = gnd;
      w[B_MODE_LO +: 2] = mode;
      w[B_BIAS]         = bias;
      return w;
   endfunction

   localparam logic [CW_W-1:0] CW_INTR  = cw_make(4'b0011, 4'b1100, PM_INTR, 1'b0);
   localparam logic [CW_W-1:0] CW_XPRES = cw_make(4'b0010, 4'b0001, PM_PRES, 1'b1);
   localparam logic [CW_W-1:0] CW_XPOS  = cw_make(4'b0010, 4'b0001, PM_POS,  1'b1);
   localparam logic [CW_W-1:0] CW_YPRES = cw_make(4'b1000, 4'b0100, PM_PRES, 1'b1);
   localparam logic [CW_W-1:0] CW_YPOS  = cw_make(4'b1000, 4'b0100, PM_POS,  1'b1);
   localparam logic [CW_W-1:0] CW_FORCE = cw_make(4'b0011, 4'b1100, PM_PRES, 1'b1);

endpackage

// File: rtl/tss_timer.sv
module tss_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/tss_word_map.sv
module tss_word_map
   import tss_pkg::*;
#(
   parameter int CHAN_W = 3
) (
   input  scan_st_e           st_i,
   output logic [CW_W-1:0]    word_o,
   output logic               en_o,
   output logic               req_o,
   output logic [CHAN_W-1:0]  chan_o
);

   always_comb begin
      word_o = CW_INTR;
      en_o   = 1'b1;
      req_o  = 1'b0;
      chan_o = '0;
      unique case (st_i)
         ST_IDLE, ST_PENWAIT, ST_DECIDE, ST_RESCAN: en_o = 1'b0;
         ST_ADC_ON:      word_o = CW_INTR;
         ST_XW1, ST_XW2: word_o = CW_XPRES;
         ST_XW3, ST_XSET: word_o = CW_XPOS;
         ST_XCONV: begin
            word_o = CW_XPOS;
            req_o  = 1'b1;
            chan_o = CHAN_W'(CH_PLUS_Y);
         end
         ST_YW1, ST_YW2: word_o = CW_YPRES;
         ST_YW3, ST_YSET: word_o = CW_YPOS;
         ST_YCONV: begin
            word_o = CW_YPOS;
            req_o  = 1'b1;
            chan_o = CHAN_W'(CH_PLUS_X);
         end
         ST_PW, ST_PSET: word_o = CW_FORCE;
         ST_PCONV: begin
            word_o = CW_FORCE;
            req_o  = 1'b1;
            chan_o = CHAN_W'(CH_PLUS_Y);
         end
         default: en_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
   import tss_pkg::*;
#(
   parameter int CLK_MHZ        = 125,
   parameter int POS_SETTLE_US  = 55,
   parameter int PRES_SETTLE_US = 0,
   parameter int PEN_SETTLE_US  = 10000,
   parameter int RESCAN_US      = 10000,
   parameter int ADC_W          = 10,
   parameter int CHAN_W         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pen_irq_i,
   input  logic              restart_i,
   input  logic [1:0]        sense_i,
   input  logic              adc_done_i,
   input  logic [ADC_W-1:0]  adc_data_i,
   output logic [15:0]       ctrl_word_o,
   output logic              adc_en_o,
   output logic              adc_req_o,
   output logic [CHAN_W-1:0] adc_chan_o,
   output logic              pen_arm_o,
   output logic              sample_vld_o,
   output logic              release_o,
   output logic [ADC_W-1:0]  x_o,
   output logic [ADC_W-1:0]  y_o,
   output logic [ADC_W-1:0]  p_o
);

   localparam int POS_CYC  = CLK_MHZ * POS_SETTLE_US;
   localparam int PRES_CYC = CLK_MHZ * PRES_SETTLE_US;
   localparam int PEN_CYC  = CLK_MHZ * PEN_SETTLE_US;
   localparam int RES_CYC  = CLK_MHZ * RESCAN_US;
   localparam int MAX_A    = (POS_CYC > PRES_CYC) ? POS_CYC : PRES_CYC;
   localparam int MAX_B    = (PEN_CYC > RES_CYC) ? PEN_CYC : RES_CYC;
   localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TMR_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   localparam logic [TMR_W-1:0] POS_LD  = TMR_W'((POS_CYC  > 0) ? POS_CYC  - 1 : 0);
   localparam logic [TMR_W-1:0] PRES_LD = TMR_W'((PRES_CYC > 0) ? PRES_CYC - 1 : 0);
   localparam logic [TMR_W-1:0] PEN_LD  = TMR_W'((PEN_CYC  > 0) ? PEN_CYC  - 1 : 0);
   localparam logic [TMR_W-1:0] RES_LD  = TMR_W'((RES_CYC  > 0) ? RES_CYC  - 1 : 0);

   // elaboration-time parameter checks
   if (ADC_W < 1 || ADC_W > 16) begin : g_bad_adc_w
      $error("touch_scan_seq: ADC_W must be 1..16");
   end
   if (CHAN_W < 2) begin : g_bad_chan_w
      $error("touch_scan_seq: CHAN_W must hold channel code 2");
   end
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("touch_scan_seq: CLK_MHZ must be positive");
   end
   if (POS_SETTLE_US < 0 || PRES_SETTLE_US < 0 || PEN_SETTLE_US < 0 || RESCAN_US < 0) begin : g_bad_dly
      $error("touch_scan_seq: delays must not be negative");
   end

   // variant selection: a zero delay removes its wait state
   logic has_pos, has_pres, has_pen, has_res;
   if (POS_CYC > 0) begin : g_pos_wait
      assign has_pos = 1'b1;
   end else begin : g_pos_none
      assign has_pos = 1'b0;
   end
   if (PRES_CYC > 0) begin : g_pres_wait
      assign has_pres = 1'b1;
   end else begin : g_pres_none
      assign has_pres = 1'b0;
   end
   if (PEN_CYC > 0) begin : g_pen_wait
      assign has_pen = 1'b1;
   end else begin : g_pen_none
      assign has_pen = 1'b0;
   end
   if (RES_CYC > 0) begin : g_res_wait
      assign has_res = 1'b1;
   end else begin : g_res_none
      assign has_res = 1'b0;
   end

   scan_st_e         st, nxt;
   logic             tmr_ld, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             go, touched, had_sample;
   logic [ADC_W-1:0] x_raw, y_raw, p_raw;

   assign go      = pen_irq_i | restart_i;
   assign touched = (sense_i == 2'b00);

   tss_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   tss_word_map #(.CHAN_W(CHAN_W)) u_map (
      .st_i   (st),
      .word_o (ctrl_word_o),
      .en_o   (adc_en_o),
      .req_o  (adc_req_o),
      .chan_o (adc_chan_o)
   );

   always_comb begin
      nxt     = st;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      unique case (st)
         ST_IDLE:   if (go) nxt = ST_ADC_ON;
         ST_ADC_ON: nxt = ST_XW1;
         ST_XW1:    nxt = ST_XW2;
         ST_XW2:    nxt = ST_XW3;
         ST_XW3: begin
            if (has_pos) begin
               nxt = ST_XSET; tmr_ld = 1'b1; tmr_val = POS_LD;
            end else nxt = ST_XCONV;
         end
         ST_XSET:   if (tmr_zero) nxt = ST_XCONV;
         ST_XCONV:  if (adc_done_i) nxt = ST_YW1;
         ST_YW1:    nxt = ST_YW2;
         ST_YW2:    nxt = ST_YW3;
         ST_YW3: begin
            if (has_pos) begin
               nxt = ST_YSET; tmr_ld = 1'b1; tmr_val = POS_LD;
            end else nxt = ST_YCONV;
         end
         ST_YSET:   if (tmr_zero) nxt = ST_YCONV;
         ST_YCONV:  if (adc_done_i) nxt = ST_PW;
         ST_PW: begin
            if (has_pres) begin
               nxt = ST_PSET; tmr_ld = 1'b1; tmr_val = PRES_LD;
            end else nxt = ST_PCONV;
         end
         ST_PSET:   if (tmr_zero) nxt = ST_PCONV;
         ST_PCONV: begin
            if (adc_done_i) begin
               if (has_pen) begin
                  nxt = ST_PENWAIT; tmr_ld = 1'b1; tmr_val = PEN_LD;
               end else nxt = ST_DECIDE;
            end
         end
         ST_PENWAIT: if (tmr_zero) nxt = ST_DECIDE;
         ST_DECIDE: begin
            if (!touched) nxt = ST_IDLE;
            else if (has_res) begin
               nxt = ST_RESCAN; tmr_ld = 1'b1; tmr_val = RES_LD;
            end else nxt = ST_ADC_ON;
         end
         ST_RESCAN: if (go || tmr_zero) nxt = ST_ADC_ON;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   // conversion results of the pass in progress
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_raw <= '0;
         y_raw <= '0;
         p_raw <= '0;
      end else if (adc_done_i) begin
         if (st == ST_XCONV) x_raw <= adc_data_i;
         if (st == ST_YCONV) y_raw <= adc_data_i;
         if (st == ST_PCONV) p_raw <= adc_data_i;
      end
   end

   // pen decision and output strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_vld_o <= 1'b0;
         release_o    <= 1'b0;
         pen_arm_o    <= 1'b0;
         had_sample   <= 1'b0;
         x_o          <= '0;
         y_o          <= '0;
         p_o          <= '0;
      end else begin
         sample_vld_o <= 1'b0;
         release_o    <= 1'b0;
         pen_arm_o    <= 1'b0;
         if (st == ST_DECIDE) begin
            if (touched) begin
               sample_vld_o <= 1'b1;
               had_sample   <= 1'b1;
               x_o          <= x_raw;
               y_o          <= y_raw;
               p_o          <= p_raw;
            end else begin
               pen_arm_o  <= 1'b1;
               release_o  <= had_sample;
               had_sample <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/touch_scan_seq_chk.sv
module touch_scan_seq_chk
   import tss_pkg::*;
#(
   parameter int CHAN_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_done_i,
   input logic [15:0]       ctrl_word_o,
   input logic              adc_en_o,
   input logic              adc_req_o,
   input logic [CHAN_W-1:0] adc_chan_o,
   input logic              pen_arm_o,
   input logic              sample_vld_o,
   input logic              release_o
);

   assert_quiet_intr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_en_o |-> ctrl_word_o == CW_INTR);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req_o && !adc_done_i |=> adc_req_o && $stable(adc_chan_o) && $stable(ctrl_word_o));

   assert_plusx_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req_o && adc_chan_o == CHAN_W'(CH_PLUS_X) |-> ctrl_word_o == CW_YPOS);

   assert_pres_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req_o && ctrl_word_o[B_MODE_LO +: 2] == PM_PRES |-> adc_chan_o == CHAN_W'(CH_PLUS_Y));

   assert_req_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req_o |-> adc_en_o && ctrl_word_o[B_BIAS]);

   assert_sample_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |=> !sample_vld_o);

   assert_release_with_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |-> pen_arm_o && !sample_vld_o);

endmodule

bind touch_scan_seq touch_scan_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adc_done_i   (adc_done_i),
   .ctrl_word_o  (ctrl_word_o),
   .adc_en_o     (adc_en_o),
   .adc_req_o    (adc_req_o),
   .adc_chan_o   (adc_chan_o),
   .pen_arm_o    (pen_arm_o),
   .sample_vld_o (sample_vld_o),
   .release_o    (release_o)
);

// File: tb/tb_touch_scan_seq.sv
`timescale 1ns/1ps
module tb_touch_scan_seq;

   localparam int MHZ = 2, POS_US = 3, PRES_US = 0, PEN_US = 5, RES_US = 8;
   localparam int POS = MHZ * POS_US, PRES = MHZ * PRES_US;
   localparam int PEN = MHZ * PEN_US, RES = MHZ * RES_US;
   localparam int AW = 10, CW = 3;

   localparam logic [15:0] W_INT = 16'h00C3, W_XP = 16'h0912, W_XQ = 16'h0A12;
   localparam logic [15:0] W_YP = 16'h0948, W_YQ = 16'h0A48, W_PP = 16'h09C3;

   logic clk = 1'b0, rst_n = 1'b0, pen_irq = 1'b0, restart = 1'b0;
   logic [1:0] sense = 2'b00;
   logic adc_done = 1'b0;
   logic [AW-1:0] adc_data = '0;
   logic [15:0] ctrl_word;
   logic adc_en, adc_req, pen_arm, sample_vld, release_s;
   logic [CW-1:0] adc_chan;
   logic [AW-1:0] x_s, y_s, p_s;

   always #4 clk = ~clk;

   touch_scan_seq #(.CLK_MHZ(MHZ), .POS_SETTLE_US(POS_US), .PRES_SETTLE_US(PRES_US),
      .PEN_SETTLE_US(PEN_US), .RESCAN_US(RES_US), .ADC_W(AW), .CHAN_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .pen_irq_i(pen_irq), .restart_i(restart), .sense_i(sense),
      .adc_done_i(adc_done), .adc_data_i(adc_data), .ctrl_word_o(ctrl_word),
      .adc_en_o(adc_en), .adc_req_o(adc_req), .adc_chan_o(adc_chan), .pen_arm_o(pen_arm),
      .sample_vld_o(sample_vld), .release_o(release_s), .x_o(x_s), .y_o(y_s), .p_o(p_s));

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // ADC responder: done after a programmable number of request cycles
   int lat = 2, lat_cnt = 0;
   logic [AW-1:0] dval = 10'h155;
   initial begin
      forever begin
         @(posedge clk); #1;
         if (adc_done) adc_done = 1'b0;
         else if (adc_req) begin
            if (lat_cnt >= lat) begin
               adc_done = 1'b1; adc_data = dval; dval = dval + 10'd97; lat_cnt = 0;
            end else lat_cnt++;
         end
      end
   end

   // behavioural reference model: expected outputs for every cycle
   logic [15:0] e_cw = W_INT;
   logic e_en = 0, e_req = 0, e_vld = 0, e_rel = 0, e_arm = 0;
   logic [CW-1:0] e_ch = '0;
   logic [AW-1:0] e_x = '0, e_y = '0, e_p = '0;
   string e_tag = "R1";
   bit model_on = 0;

   task automatic cyc(input string tag, input logic [15:0] w, input logic en,
                      input logic rq, input logic [CW-1:0] ch);
      e_tag = tag; e_cw = w; e_en = en; e_req = rq; e_ch = ch;
      @(posedge clk);
      e_vld = 0; e_rel = 0; e_arm = 0;
   endtask

   task automatic conv(input string tag, input logic [15:0] w, input logic [CW-1:0] ch,
                       output logic [AW-1:0] d);
      do cyc(tag, w, 1, 1, ch); while (!adc_done);
      d = adc_data;
   endtask

   initial begin
      logic [AW-1:0] mx, my, mp;
      bit valid = 0, leave;
      wait (rst_n === 1'b1);
      model_on = 1;
      forever begin
         do cyc("R2", W_INT, 0, 0, 0); while (!(pen_irq || restart));
         leave = 0;
         while (!leave) begin
            cyc("R7", W_INT, 1, 0, 0);
            cyc("R3/R4", W_XP, 1, 0, 0); cyc("R3/R4", W_XP, 1, 0, 0); cyc("R4", W_XQ, 1, 0, 0);
            repeat (POS) cyc("R12", W_XQ, 1, 0, 0);
            conv("R4", W_XQ, 3'd2, mx);
            cyc("R5", W_YP, 1, 0, 0); cyc("R5", W_YP, 1, 0, 0); cyc("R5", W_YQ, 1, 0, 0);
            repeat (POS) cyc("R12", W_YQ, 1, 0, 0);
            conv("R5", W_YQ, 3'd0, my);
            cyc("R6", W_PP, 1, 0, 0);
            repeat (PRES) cyc("R6", W_PP, 1, 0, 0);
            conv("R6", W_PP, 3'd2, mp);
            repeat (PEN) cyc("R8", W_INT, 0, 0, 0);
            cyc("R8", W_INT, 0, 0, 0);
            if (sense != 2'b00) begin
               e_arm = 1; e_rel = valid; valid = 0; leave = 1;
            end else begin
               e_vld = 1; e_x = mx; e_y = my; e_p = mp; valid = 1;
               for (int i = 0; i < RES; i++) begin
                  cyc("R11", W_INT, 0, 0, 0);
                  if (pen_irq || restart) break;
               end
            end
         end
      end
   end

   // compare every cycle, away from the active edge
   int n_vld = 0, n_rel = 0, n_arm = 0, n_posq = 0, idle_en = 0;
   bit idle_win = 0;
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk(e_tag, "ctrl_word", ctrl_word, e_cw);
         chk(e_tag, "adc_en", adc_en, e_en);
         chk(e_tag, "adc_req", adc_req, e_req);
         chk(e_tag, "adc_chan", adc_chan, e_ch);
         chk("R9", "sample_vld", sample_vld, e_vld);
         chk("R10", "release", release_s, e_rel);
         chk("R10", "pen_arm", pen_arm, e_arm);
         chk("R9", "x", x_s, e_x);
         chk("R9", "y", y_s, e_y);
         chk("R9", "p", p_s, e_p);
         if (sample_vld) n_vld++;
         if (release_s) n_rel++;
         if (pen_arm) n_arm++;
         if (ctrl_word == W_XQ && !adc_req) n_posq++;
         if (idle_win && adc_en) idle_en++;
      end
   end

   task automatic pulse_pen();
      @(posedge clk); #1 pen_irq = 1'b1;
      @(posedge clk); #1 pen_irq = 1'b0;
   endtask

   task automatic pulse_restart();
      @(posedge clk); #1 restart = 1'b1;
      @(posedge clk); #1 restart = 1'b0;
   endtask

   // which: 0 sample, 1 release, 2 pen re-arm
   task automatic wait_for(input int which);
      int n = 0;
      do begin
         @(negedge clk); n++;
      end while (!((which == 0 && sample_vld) || (which == 1 && release_s) ||
                   (which == 2 && pen_arm)) && n < 2000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset ctrl_word", ctrl_word, W_INT);
      chk("R1", "reset adc_en/req", {adc_en, adc_req}, 0);
      chk("R1", "reset strobes", {sample_vld, release_s, pen_arm}, 0);
      chk("R1", "reset results", {x_s, y_s, p_s}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      idle_win = 1;
      repeat (20) @(negedge clk);
      idle_win = 0;
      chk("R2", "ADC enabled while idle", idle_en, 0);

      // touched pass started by restart, then release after rescan timeout
      sense = 2'b00; lat = 2;
      pulse_restart();
      wait_for(0);
      chk("R4", "first X result", x_s, 10'h155);
      chk("R5", "first Y result", y_s, 10'h1B6);
      chk("R6", "first pressure result", p_s, 10'h217);
      sense = 2'b01; lat = 0;
      wait_for(1);
      repeat (10) @(negedge clk);

      // untouched pass with no previous sample: re-arm only
      sense = 2'b10; lat = 3;
      pulse_pen();
      wait_for(2);
      repeat (10) @(negedge clk);

      // touched, then early rescan by pen interrupt, then release
      sense = 2'b00; lat = 1;
      pulse_pen();
      wait_for(0);
      repeat (3) @(negedge clk);
      pulse_pen();
      wait_for(0);
      sense = 2'b11; lat = 0;
      wait_for(1);
      repeat (10) @(negedge clk);

      chk("R9", "sample strobes seen", n_vld, 3);
      chk("R10", "release strobes seen", n_rel, 2);
      chk("R10", "re-arm strobes seen", n_arm, 3);
      chk("R12", "X position-mode non-request cycles", n_posq, 6 * (POS + 1));
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule